// File: doc/BRIEF.md
# Buffer Transfer Byte Counter

This block runs length-terminated data transfers between a host microprocessor port and one of two on-chip buffer RAM regions. One region holds isochronous transfer lists and the other holds acknowledged transfer lists. Software sets up a transfer through a small command-coded register port. It chooses the region, the direction and the termination source, loads a 16-bit byte count, and then sets a DMA enable bit. The block then raises a DMA request. Each accepted data strobe moves one 16-bit word, which is two bytes.

The transfer ends in one of two ways. In counter mode, it ends when the bytes moved reach the loaded count. In external mode, it ends when an external end-of-transfer input is asserted. When the transfer ends, the block drops the request in the same cycle that its internal end-of-transfer pulse rises. The pulse then sets a latched interrupt status bit and a per-region buffer-full flag, and it clears the DMA enable bit. A count larger than the selected region can hold is clamped to that region's size and flagged as an error. The interrupt pin combines the status bits, a per-bit enable mask and a global enable.

Top module: `byte_xfer_counter`

## Requirements
- R1: After reset the count register reads 0, the configuration reads 0, interrupt status reads 0x000C (end-of-transfer bit 2 and count-error bit 3 both set), dmaReq is 0 and intPin is 0.
- R2: The command byte's bit 7 marks a write and bits 6:0 select the register. The count register is written with code 0xA2 and read with 0x22. The configuration register is written with 0xA1 and read with 0x21, with these bits: 0 direction (1 = write into buffer RAM), 1 region (1 = acknowledged-list buffer), 2 counter select (1 = internal count ends the transfer), 3 DMA enable. The outputs dmaToRam and dmaAtl follow bits 0 and 1.
- R3: A count write above the selected region's ceiling (0x800 for the isochronous region, 0x1000 for the acknowledged region) stores the ceiling and sets status bit 3. A write at or below the ceiling is stored unchanged and leaves bit 3 clear.
- R4: In counter mode, dmaReq is asserted after DMA enable is set only if the count register is non-zero.
- R5: Each cycle with both dmaAck and dmaReq high moves 2 bytes. In counter mode, dmaReq stays high for exactly ceil(count/2) accepted strobes and is low from the cycle after the last one.
- R6: End of transfer sets status bit 2. It also sets the buffer status flag of the selected region (read code 0x2C, bit 0 for the isochronous region, bit 1 for the acknowledged region) and clears configuration bit 3.
- R7: In external mode, dmaReq is asserted after enable even with a count of 0, and extEot asserted while dmaReq is high ends the transfer.
- R8: After an end of transfer, setting DMA enable again without a new count write leaves dmaReq low.
- R9: Writing 1s with code 0xA4 clears the matching status bits. The enable mask is written with code 0xA5, and the global enable is bit 0 of code 0xA0. intPin is high only when some status bit and its mask bit are set and the global enable is set.
- R10: A count write clears the buffer status flag of the currently selected region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Register access strobe |
| cmdCode | input | 8 | Command code: bit 7 write, bits 6:0 register |
| cmdWrData | input | 16 | Write data |
| cmdRdData | output | 16 | Read data for a valid read command (combinational) |
| dmaAck | input | 1 | Data strobe; one 16-bit word moves when high together with dmaReq |
| extEot | input | 1 | External end-of-transfer request |
| dmaReq | output | 1 | DMA request |
| dmaToRam | output | 1 | Direction: 1 writes into buffer RAM |
| dmaAtl | output | 1 | Region: 1 selects the acknowledged-list buffer |
| intPin | output | 1 | Interrupt output |

## Verification
The assertions assume two things about the inputs. First, software never writes the configuration or the count register in the same cycle that a transfer ends. Second, extEot is only meaningful while a request is pending. The stimulus keeps to both: every register write happens with dmaAck and extEot low, and a transfer is only started after its count and configuration have settled. Random counts are drawn below, at and above each region's ceiling, with odd and zero values included. The bench then waits for the request to drop before it touches any register.

// File: rtl/bxc_pkg.sv
package bxc_pkg;
  localparam int DATA_W = 16;

  localparam logic [6:0] REG_GCTL  = 7'h20;
  localparam logic [6:0] REG_CFG   = 7'h21;
  localparam logic [6:0] REG_COUNT = 7'h22;
  localparam logic [6:0] REG_ISTAT = 7'h24;
  localparam logic [6:0] REG_IEN   = 7'h25;
  localparam logic [6:0] REG_BUFST = 7'h2C;

  localparam int CFG_DIR_BIT = 0;
  localparam int CFG_ATL_BIT = 1;
  localparam int CFG_CNT_BIT = 2;
  localparam int CFG_EN_BIT  = 3;

  typedef struct packed {
    logic              loadCount;
    logic [DATA_W-1:0] loadValue;
    logic              regionAtl;
    logic              useCounter;
    logic              dmaEn;
  } bxcStrobes_t;
endpackage

// File: rtl/bxc_ctrl.sv
module bxc_ctrl
  import bxc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [7:0]        cmdCode,
  input  logic [DATA_W-1:0] cmdWrData,
  output logic [DATA_W-1:0] cmdRdData,
  input  logic [DATA_W-1:0] countReg,
  input  logic              eot,
  input  logic              clampHit,
  output bxcStrobes_t       strb,
  output logic [1:0]        statusBits,
  output logic              dmaToRam,
  output logic              dmaAtl,
  output logic              intPin
);
  logic              isWrite;
  logic              isRead;
  logic [6:0]        regIdx;
  logic              wrCfg, wrCount, wrIstat, wrIen, wrGctl;
  logic [DATA_W-1:0] cfgReg;
  logic [DATA_W-1:0] ienReg;
  logic [DATA_W-1:0] gctlReg;
  logic [1:0]        statReg;
  logic [1:0]        bufReg;
  logic [1:0]        bufNext;
  logic [1:0]        clrMask;

  assign isWrite = cmdValid & cmdCode[7];
  assign isRead  = cmdValid & ~cmdCode[7];
  assign regIdx  = cmdCode[6:0];

  assign wrCfg   = isWrite && (regIdx == REG_CFG);
  assign wrCount = isWrite && (regIdx == REG_COUNT);
  assign wrIstat = isWrite && (regIdx == REG_ISTAT);
  assign wrIen   = isWrite && (regIdx == REG_IEN);
  assign wrGctl  = isWrite && (regIdx == REG_GCTL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg <= '0;
    end else if (wrCfg) begin
      cfgReg <= cmdWrData;
    end else if (eot) begin
      cfgReg[CFG_EN_BIT] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ienReg  <= '0;
      gctlReg <= '0;
    end else begin
      if (wrIen)  ienReg  <= cmdWrData;
      if (wrGctl) gctlReg <= cmdWrData;
    end
  end

  assign clrMask = wrIstat ? cmdWrData[3:2] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statReg <= 2'b11;
    end else begin
      statReg <= (statReg & ~clrMask) | {clampHit, eot};
    end
  end

  always_comb begin
    bufNext = bufReg;
    if (wrCount) bufNext[cfgReg[CFG_ATL_BIT]] = 1'b0;
    if (eot)     bufNext[cfgReg[CFG_ATL_BIT]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) bufReg <= '0;
    else       bufReg <= bufNext;
  end

  always_comb begin
    cmdRdData = '0;
    if (isRead) begin
      case (regIdx)
        REG_GCTL:  cmdRdData = gctlReg;
        REG_CFG:   cmdRdData = cfgReg;
        REG_COUNT: cmdRdData = countReg;
        REG_ISTAT: cmdRdData = {{(DATA_W-4){1'b0}}, statReg, 2'b00};
        REG_IEN:   cmdRdData = ienReg;
        REG_BUFST: cmdRdData = {{(DATA_W-2){1'b0}}, bufReg};
        default:   cmdRdData = '0;
      endcase
    end
  end

  always_comb begin
    strb.loadCount  = wrCount;
    strb.loadValue  = cmdWrData;
    strb.regionAtl  = cfgReg[CFG_ATL_BIT];
    strb.useCounter = cfgReg[CFG_CNT_BIT];
    strb.dmaEn      = cfgReg[CFG_EN_BIT];
  end

  assign statusBits = statReg;
  assign dmaToRam   = cfgReg[CFG_DIR_BIT];
  assign dmaAtl     = cfgReg[CFG_ATL_BIT];
  assign intPin     = gctlReg[0] & |(statReg & ienReg[3:2]);
endmodule

// File: rtl/bxc_datapath.sv
module bxc_datapath
  import bxc_pkg::*;
#(
  parameter int ITL_MAX = 2048,
  parameter int ATL_MAX = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  bxcStrobes_t       strb,
  input  logic              dmaAck,
  input  logic              extEot,
  output logic [DATA_W-1:0] countReg,
  output logic              dmaReq,
  output logic              eot,
  output logic              clampHit
);
  localparam logic [DATA_W-1:0] ITL_LIM = DATA_W'(ITL_MAX);
  localparam logic [DATA_W-1:0] ATL_LIM = DATA_W'(ATL_MAX);
  localparam int MW = DATA_W + 1;

  logic [DATA_W-1:0] limit;
  logic              overLimit;
  logic [DATA_W-1:0] clamped;
  logic [MW-1:0]     moved;
  logic [MW-1:0]     movedNext;
  logic              done;
  logic              strobe;
  logic              lastBeat;
  logic              extStop;

  assign limit     = strb.regionAtl ? ATL_LIM : ITL_LIM;
  assign overLimit = strb.loadValue > limit;
  assign clamped   = overLimit ? limit : strb.loadValue;

  assign dmaReq    = strb.dmaEn && !done && (strb.useCounter ? (countReg != '0) : 1'b1);
  assign strobe    = dmaAck && dmaReq;
  assign movedNext = moved + MW'(2);
  assign lastBeat  = strb.useCounter && (movedNext >= {1'b0, countReg});
  assign extStop   = !strb.useCounter && dmaReq && extEot;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countReg <= '0;
      moved    <= '0;
      done     <= 1'b0;
      eot      <= 1'b0;
      clampHit <= 1'b0;
    end else begin
      eot      <= 1'b0;
      clampHit <= 1'b0;
      if (strb.loadCount) begin
        countReg <= clamped;
        clampHit <= overLimit;
        moved    <= '0;
        done     <= 1'b0;
      end else begin
        if (strobe) moved <= movedNext;
        if ((strobe && lastBeat) || extStop) begin
          done <= 1'b1;
          eot  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/byte_xfer_counter.sv
module byte_xfer_counter
  import bxc_pkg::*;
#(
  parameter int ITL_MAX = 2048,
  parameter int ATL_MAX = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [7:0]        cmdCode,
  input  logic [DATA_W-1:0] cmdWrData,
  output logic [DATA_W-1:0] cmdRdData,
  input  logic              dmaAck,
  input  logic              extEot,
  output logic              dmaReq,
  output logic              dmaToRam,
  output logic              dmaAtl,
  output logic              intPin
);
  bxcStrobes_t       strb;
  logic [DATA_W-1:0] countReg;
  logic              eot;
  logic              clampHit;
  logic [1:0]        statusBits;

  bxc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdWrData(cmdWrData), .cmdRdData(cmdRdData), .countReg(countReg),
    .eot(eot), .clampHit(clampHit), .strb(strb), .statusBits(statusBits),
    .dmaToRam(dmaToRam), .dmaAtl(dmaAtl), .intPin(intPin)
  );

  bxc_datapath #(.ITL_MAX(ITL_MAX), .ATL_MAX(ATL_MAX)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dmaAck(dmaAck), .extEot(extEot),
    .countReg(countReg), .dmaReq(dmaReq), .eot(eot), .clampHit(clampHit)
  );
endmodule

// File: rtl/bxc_checker.sv
module bxc_checker
  import bxc_pkg::*;
#(
  parameter int ATL_MAX = 4096
) (
  input logic              clk,
  input logic              rstN,
  input logic              dmaReq,
  input logic              eot,
  input logic              useCounter,
  input logic              loadCount,
  input logic [DATA_W-1:0] countReg,
  input logic              intPin,
  input logic              extEot,
  input logic [1:0]        statusBits
);
  AST_COUNT_CEILING: assert property (@(posedge clk) disable iff (!rstN)
    countReg <= DATA_W'(ATL_MAX)); // R3
  AST_ZERO_COUNT_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (useCounter && countReg == '0) |-> !dmaReq); // R4
  AST_REQ_DROPS_AT_EOT: assert property (@(posedge clk) disable iff (!rstN)
    eot |-> !dmaReq); // R5
  AST_EOT_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    eot |=> !eot); // R5
  AST_EOT_SETS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    eot |=> statusBits[0]); // R6
  AST_EXT_EOT_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (!useCounter && dmaReq && extEot && !loadCount) |=> !dmaReq); // R7
  AST_INT_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    intPin |-> (statusBits != 2'b00)); // R9
endmodule

bind byte_xfer_counter bxc_checker #(.ATL_MAX(ATL_MAX)) u_chk (
  .clk(clk), .rstN(rstN), .dmaReq(dmaReq), .eot(eot),
  .useCounter(strb.useCounter), .loadCount(strb.loadCount),
  .countReg(countReg), .intPin(intPin), .extEot(extEot),
  .statusBits(statusBits)
);

// File: tb/byte_xfer_counter_test.sv
module byte_xfer_counter_test;
  localparam int ITL_MAX = 2048;
  localparam int ATL_MAX = 4096;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [7:0]  cmdCode = '0;
  logic [15:0] cmdWrData = '0;
  logic [15:0] cmdRdData;
  logic        dmaAck = 1'b0;
  logic        extEot = 1'b0;
  logic        dmaReq, dmaToRam, dmaAtl, intPin;

  int checks = 0;
  int fails = 0;

  byte_xfer_counter #(.ITL_MAX(ITL_MAX), .ATL_MAX(ATL_MAX)) uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdWrData(cmdWrData), .cmdRdData(cmdRdData), .dmaAck(dmaAck),
    .extEot(extEot), .dmaReq(dmaReq), .dmaToRam(dmaToRam),
    .dmaAtl(dmaAtl), .intPin(intPin)
  );

  always #5 clk = ~clk;

  function automatic int expClamp(input bit atl, input int cnt);
    int lim = atl ? ATL_MAX : ITL_MAX;
    return (cnt > lim) ? lim : cnt;
  endfunction

  function automatic int expStrobes(input int cnt);
    return (cnt + 1) / 2;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [6:0] idx, input logic [15:0] d);
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = {1'b1, idx}; cmdWrData = d;
    @(negedge clk);
    cmdValid = 1'b0; cmdCode = '0; cmdWrData = '0;
  endtask

  task automatic regRead(input logic [6:0] idx, output int d);
    cmdValid = 1'b1; cmdCode = {1'b0, idx};
    #1;
    d = int'(cmdRdData);
    cmdValid = 1'b0; cmdCode = '0;
  endtask

  task automatic runXfer(input bit atl, input bit dir, input int cnt);
    int clampV, rd, n;
    logic [15:0] cfg;
    clampV = expClamp(atl, cnt);
    cfg = 16'h0004 | (16'(atl) << 1) | 16'(dir);
    regWrite(7'h21, cfg);
    regWrite(7'h22, 16'(cnt));
    @(negedge clk);
    regRead(7'h22, rd);   check("R3 stored count", rd, clampV);
    regRead(7'h24, rd);   check("R3 error bit", (rd >> 3) & 1, (cnt > clampV) ? 1 : 0);
    regRead(7'h2C, rd);   check("R10 buffer flag cleared", (rd >> atl) & 1, 0);
    check("R2 direction out", int'(dmaToRam), int'(dir));
    check("R2 region out", int'(dmaAtl), int'(atl));
    regWrite(7'h24, 16'h000C);
    regWrite(7'h21, cfg | 16'h0008);
    check("R4 request after enable", int'(dmaReq), (clampV != 0) ? 1 : 0);
    dmaAck = 1'b1;
    n = 0;
    while (dmaReq && n < 5000) begin
      n++;
      @(negedge clk);
    end
    dmaAck = 1'b0;
    check("R5 strobe count", n, expStrobes(clampV));
    @(negedge clk);
    regRead(7'h24, rd);   check("R6 eot status", (rd >> 2) & 1, (clampV != 0) ? 1 : 0);
    if (clampV != 0) begin
      regRead(7'h2C, rd); check("R6 buffer flag set", (rd >> atl) & 1, 1);
      regRead(7'h21, rd); check("R6 enable cleared", (rd >> 3) & 1, 0);
      regWrite(7'h21, cfg | 16'h0008);
      check("R8 no restart without count", int'(dmaReq), 0);
      regWrite(7'h21, cfg);
    end
    regWrite(7'h24, 16'h000C);
  endtask

  initial begin
    int rd;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    regRead(7'h22, rd); check("R1 count reset", rd, 0);
    regRead(7'h21, rd); check("R1 config reset", rd, 0);
    regRead(7'h24, rd); check("R1 status reset", rd, 16'h000C);
    check("R1 request reset", int'(dmaReq), 0);
    check("R1 int reset", int'(intPin), 0);

    regWrite(7'h25, 16'h0004);
    check("R9 mask without global", int'(intPin), 0);
    regWrite(7'h20, 16'h0001);
    check("R9 mask with global", int'(intPin), 1);
    regWrite(7'h24, 16'h0004);
    check("R9 cleared masked bit", int'(intPin), 0);
    regRead(7'h24, rd); check("R9 other bit kept", rd, 16'h0008);
    regWrite(7'h24, 16'h0008);
    regRead(7'h24, rd); check("R9 all cleared", rd, 0);

    // R4 zero count in counter mode
    regWrite(7'h21, 16'h0004);
    regWrite(7'h22, 16'h0000);
    regWrite(7'h21, 16'h000C);
    check("R4 zero count holds request", int'(dmaReq), 0);
    regWrite(7'h21, 16'h0000);

    // R7 external termination
    regWrite(7'h22, 16'h0000);
    regWrite(7'h21, 16'h0008);
    check("R7 request with zero count", int'(dmaReq), 1);
    dmaAck = 1'b1;
    repeat (5) @(negedge clk);
    dmaAck = 1'b0;
    check("R7 still requesting", int'(dmaReq), 1);
    extEot = 1'b1;
    @(negedge clk);
    extEot = 1'b0;
    check("R7 request dropped", int'(dmaReq), 0);
    @(negedge clk);
    regRead(7'h24, rd); check("R6 ext eot status", rd, 16'h0004);
    check("R9 int on eot", int'(intPin), 1);
    regRead(7'h2C, rd); check("R6 isochronous flag", rd & 1, 1);
    regWrite(7'h21, 16'h0008);
    check("R8 ext no restart", int'(dmaReq), 0);
    regWrite(7'h21, 16'h0000);
    regWrite(7'h24, 16'h000C);

    // directed boundaries
    runXfer(1'b0, 1'b0, 16'h0800);
    runXfer(1'b0, 1'b1, 16'h0801);
    runXfer(1'b1, 1'b0, 16'h1000);
    runXfer(1'b1, 1'b1, 16'h1001);
    runXfer(1'b0, 1'b1, 3);
    runXfer(1'b1, 1'b0, 0);
    runXfer(1'b1, 1'b1, 16'hFFFF);

    for (int i = 0; i < 14; i++) begin
      bit atl, dir;
      int cnt;
      atl = 1'($urandom);
      dir = 1'($urandom);
      case ($urandom % 4)
        0: cnt = int'($urandom % 16);
        1: cnt = int'($urandom % ((atl ? ATL_MAX : ITL_MAX) + 1));
        2: cnt = int'($urandom % 16'h2000);
        default: cnt = (atl ? ATL_MAX : ITL_MAX) + int'($urandom % 3) - 1;
      endcase
      runXfer(atl, dir, cnt);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule